// File: doc/BRIEF.md
# Time Base Source Switchover

This block keeps a time base made of a seconds count and a sub-second cycle count, where a cycle is one period of the 125 MHz time base clock (8 ns). The block can run in two ways. In local mode it counts freely on its own clock. In synchronized mode it copies, every cycle, the seconds and cycle values that an external synchronization core supplies.

A host moves the block into synchronized mode by issuing a request. The block then waits until the external link reports up and its time reports valid. It loads the external values one cycle later, and only after that load does it report lock. If the link drops while the block is locked, it returns to local mode at once. It carries on counting from the last value it held, so time may drift but never steps. The block never returns to synchronized mode by itself.

Each gain or loss of lock sets a sticky status flag and raises an interrupt. The host clears both with a write-one-to-clear strobe.

Top module: `tbase_switch`

## Requirements
- R1: While reset is asserted, both counters read zero, the locked and waiting indications are low, and both event flags and the interrupt are low.
- R2: Outside locked mode, the cycle count advances by one on every clock. After CYC_PER_SEC-1 it returns to zero, and on that same edge the seconds count advances by one.
- R3: The seconds count wraps modulo 2^SEC_W.
- R4: A request pulse in local mode raises `st_wait` one cycle later. Once link-up and time-valid are both seen high while waiting, the next edge enters a load step. On the edge after that, the counters take the external values present at that edge, and `st_locked` rises together with the gain flag.
- R5: While locked with the link up, the counters present the external seconds and cycle values sampled at the previous clock edge.
- R6: If the link is seen down while locked, the next edge leaves locked mode. The counters take the held value advanced by one cycle (no jump), and the loss flag is set.
- R7: In local mode, with no request, the block stays unlocked even while link-up and time-valid are high.
- R8: A request made while the link is down holds `st_wait` high for as long as the link stays down. A cancel pulse while waiting or loading returns the block to local mode, and the counters keep counting.
- R9: `ev_gain` and `ev_loss` are sticky. The `irq_clr` strobe clears both of them. An event arriving on the same edge as a clear leaves its flag set. `irq` is high whenever either flag is set.
- R10: Request and cancel pulses have no effect while the block is locked.
- R11: If link-up or time-valid is low during the load step, no external values are loaded, the block goes back to waiting, and no gain event is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | time base clock |
| rst_n | input | 1 | asynchronous reset, active low |
| ext_sec | input | SEC_W | seconds value from the synchronization core |
| ext_cyc | input | CYC_W | cycle value from the synchronization core |
| ext_link_up | input | 1 | external link is up |
| ext_time_ok | input | 1 | external time is valid |
| sync_req | input | 1 | host pulse: enter synchronized mode |
| sync_cancel | input | 1 | host pulse: abandon a pending request |
| irq_clr | input | 1 | host pulse: clear event flags |
| sec_o | output | SEC_W | current seconds count |
| cyc_o | output | CYC_W | current cycle count |
| st_locked | output | 1 | counters follow the external time |
| st_wait | output | 1 | request pending (waiting or loading) |
| ev_gain | output | 1 | sticky: lock was gained |
| ev_loss | output | 1 | sticky: lock was lost |
| irq | output | 1 | interrupt, high while any event flag is set |

## Verification
The bench builds the block with CYC_PER_SEC at 10 and SEC_W at 8. With these values a carry into seconds happens every ten cycles, and the full seconds wrap of R3 comes after 2560 cycles, so both roll-overs fall inside a short run. The same small widths let the external counter used for the synchronized phases be stepped through many wraps. This also means that every fallback edge exercised under R6 can land close to a cycle or seconds carry.

// File: rtl/tbase_switch.sv
module tbase_switch #(
  parameter int unsigned SEC_W       = 32,
  parameter int unsigned CYC_PER_SEC = 125_000_000,
  localparam int unsigned CYC_W      = $clog2(CYC_PER_SEC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEC_W-1:0] ext_sec,
  input  logic [CYC_W-1:0] ext_cyc,
  input  logic             ext_link_up,
  input  logic             ext_time_ok,
  input  logic             sync_req,
  input  logic             sync_cancel,
  input  logic             irq_clr,
  output logic [SEC_W-1:0] sec_o,
  output logic [CYC_W-1:0] cyc_o,
  output logic             st_locked,
  output logic             st_wait,
  output logic             ev_gain,
  output logic             ev_loss,
  output logic             irq
);
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CYC_PER_SEC - 1);

  typedef enum logic [1:0] {S_LOCAL, S_WAIT, S_LOAD, S_LOCKED} mode_t;
  mode_t st, nxt;

  logic qual, take_ext, gain_hit, loss_hit;
  wire  wrap = (cyc_o == CYC_LAST);
  assign qual = ext_link_up & ext_time_ok;

  always_comb begin
    nxt      = st;
    take_ext = 1'b0;
    gain_hit = 1'b0;
    loss_hit = 1'b0;
    case (st)
      S_LOCAL:  if (sync_req) nxt = S_WAIT;
      S_WAIT:   if (sync_cancel) nxt = S_LOCAL;
                else if (qual) nxt = S_LOAD;
      S_LOAD:   if (sync_cancel) nxt = S_LOCAL;
                else if (qual) begin
                  nxt = S_LOCKED; take_ext = 1'b1; gain_hit = 1'b1;
                end else nxt = S_WAIT;
      S_LOCKED: if (!ext_link_up) begin
                  nxt = S_LOCAL; loss_hit = 1'b1;
                end else take_ext = 1'b1;
      default:  nxt = S_LOCAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_LOCAL;
      sec_o   <= '0;
      cyc_o   <= '0;
      ev_gain <= 1'b0;
      ev_loss <= 1'b0;
    end else begin
      st <= nxt;
      if (take_ext) begin
        sec_o <= ext_sec;
        cyc_o <= ext_cyc;
      end else begin
        cyc_o <= wrap ? '0 : cyc_o + 1'b1;
        if (wrap) sec_o <= sec_o + 1'b1;
      end
      ev_gain <= (ev_gain & ~irq_clr) | gain_hit;
      ev_loss <= (ev_loss & ~irq_clr) | loss_hit;
    end
  end

  assign st_locked = (st == S_LOCKED);
  assign st_wait   = (st == S_WAIT) || (st == S_LOAD);
  assign irq       = ev_gain | ev_loss;
endmodule

// File: rtl/tbase_switch_props.sv
module tbase_switch_props #(
  parameter int unsigned SEC_W       = 32,
  parameter int unsigned CYC_PER_SEC = 125_000_000,
  localparam int unsigned CYC_W      = $clog2(CYC_PER_SEC)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SEC_W-1:0] ext_sec,
  input logic [CYC_W-1:0] ext_cyc,
  input logic             ext_link_up,
  input logic             sync_req,
  input logic             irq_clr,
  input logic [SEC_W-1:0] sec_o,
  input logic [CYC_W-1:0] cyc_o,
  input logic             st_locked,
  input logic             st_wait,
  input logic             ev_gain,
  input logic             ev_loss
);
  localparam logic [CYC_W-1:0] LAST = CYC_W'(CYC_PER_SEC - 1);

  logic pv;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pv <= 1'b0;
    else        pv <= 1'b1;

  p_cyc_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_o <= LAST);

  p_free_run_r2: assert property (@(posedge clk) disable iff (!rst_n || !pv)
    (!st_locked && !$past(st_locked)) |->
      (cyc_o == (($past(cyc_o) == LAST) ? '0 : CYC_W'($past(cyc_o) + 1'b1))));

  p_no_jump_r6: assert property (@(posedge clk) disable iff (!rst_n || !pv)
    $fell(st_locked) |->
      (sec_o == (($past(cyc_o) == LAST) ? SEC_W'($past(sec_o) + 1'b1) : $past(sec_o))) && ev_loss);

  p_follow_r5: assert property (@(posedge clk) disable iff (!rst_n || !pv)
    ($past(st_locked) && st_locked) |->
      (sec_o == $past(ext_sec) && cyc_o == $past(ext_cyc) && $past(ext_link_up)));

  p_no_auto_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_locked && !st_wait && !sync_req) |=> !st_locked && !st_wait);

  p_gain_flag_r9: assert property (@(posedge clk) disable iff (!rst_n || !pv)
    $rose(st_locked) |-> ev_gain);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_loss && !irq_clr) |=> ev_loss);

  p_mode_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({st_locked, st_wait}) <= 1);
endmodule

bind tbase_switch tbase_switch_props #(.SEC_W(SEC_W), .CYC_PER_SEC(CYC_PER_SEC)) u_props (
  .clk(clk), .rst_n(rst_n), .ext_sec(ext_sec), .ext_cyc(ext_cyc),
  .ext_link_up(ext_link_up), .sync_req(sync_req), .irq_clr(irq_clr),
  .sec_o(sec_o), .cyc_o(cyc_o), .st_locked(st_locked), .st_wait(st_wait),
  .ev_gain(ev_gain), .ev_loss(ev_loss)
);

// File: tb/tbase_switch_test.sv
`timescale 1ns/1ps
module tbase_switch_test;
  localparam int SW  = 8;
  localparam int CPS = 10;
  localparam int CW  = $clog2(CPS);
  localparam int SMOD = 1 << SW;

  logic clk = 0, rst_n = 0;
  logic [SW-1:0] ext_sec = '0;
  logic [CW-1:0] ext_cyc = '0;
  logic ext_link_up = 0, ext_time_ok = 0, sync_req = 0, sync_cancel = 0, irq_clr = 0;
  logic [SW-1:0] sec_o;
  logic [CW-1:0] cyc_o;
  logic st_locked, st_wait, ev_gain, ev_loss, irq;

  tbase_switch #(.SEC_W(SW), .CYC_PER_SEC(CPS)) uut (
    .clk(clk), .rst_n(rst_n), .ext_sec(ext_sec), .ext_cyc(ext_cyc),
    .ext_link_up(ext_link_up), .ext_time_ok(ext_time_ok), .sync_req(sync_req),
    .sync_cancel(sync_cancel), .irq_clr(irq_clr), .sec_o(sec_o), .cyc_o(cyc_o),
    .st_locked(st_locked), .st_wait(st_wait), .ev_gain(ev_gain), .ev_loss(ev_loss), .irq(irq));

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // external time source, advancing each cycle
  int e_sec = 100, e_cyc = 3;
  always @(negedge clk) begin
    e_cyc = e_cyc + 1;
    if (e_cyc == CPS) begin e_cyc = 0; e_sec = (e_sec + 1) % SMOD; end
    ext_sec <= SW'(e_sec);
    ext_cyc <= CW'(e_cyc);
  end

  // behavioural reference: 0 local, 1 waiting, 2 loading, 3 locked
  int m_mode = 0, m_sec = 0, m_cyc = 0, m_gain = 0, m_loss = 0;
  always @(posedge clk) begin
    int prev_sec;
    bit adv;
    prev_sec = m_sec;
    adv = 1;
    if (!rst_n) begin
      m_mode = 0; m_sec = 0; m_cyc = 0; m_gain = 0; m_loss = 0; adv = 0;
    end else begin
      if (irq_clr) begin m_gain = 0; m_loss = 0; end
      case (m_mode)
        0: if (sync_req) m_mode = 1;
        1: if (sync_cancel) m_mode = 0; else if (ext_link_up && ext_time_ok) m_mode = 2;
        2: if (sync_cancel) m_mode = 0;
           else if (ext_link_up && ext_time_ok) begin
             m_mode = 3; m_gain = 1; adv = 0; m_sec = ext_sec; m_cyc = ext_cyc;
           end else m_mode = 1;
        default: if (!ext_link_up) begin m_mode = 0; m_loss = 1; end
                 else begin adv = 0; m_sec = ext_sec; m_cyc = ext_cyc; end
      endcase
      if (adv) begin
        m_cyc = m_cyc + 1;
        if (m_cyc == CPS) begin m_cyc = 0; m_sec = (m_sec + 1) % SMOD; end
      end
    end
    #1;
    chk(m_mode == 3 ? "R5 counters" : "R2 counters", {sec_o, cyc_o}, (m_sec << CW) | m_cyc);
    chk("R4 mode flags", {st_locked, st_wait}, {m_mode == 3, m_mode == 1 || m_mode == 2});
    chk("R9 event flags", {ev_gain, ev_loss, irq}, {m_gain != 0, m_loss != 0, (m_gain | m_loss) != 0});
    if (rst_n && adv && prev_sec == SMOD - 1 && m_sec == 0)
      chk("R3 seconds wrap", sec_o, 0);
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1;
    @(negedge clk) s = 0;
  endtask

  initial begin
    int c0, s0;
    tick(3);
    chk("R1 reset counters", {sec_o, cyc_o}, 0);
    chk("R1 reset flags", {st_locked, st_wait, ev_gain, ev_loss, irq}, 0);
    rst_n = 1;
    tick(25);
    chk("R2 cycle count", cyc_o, 5);
    chk("R2 seconds carry", sec_o, 2);

    ext_link_up = 1; ext_time_ok = 1;
    tick(10);
    chk("R7 no auto lock", {st_locked, st_wait}, 0);

    pulse(sync_req);
    chk("R4 waiting", {st_locked, st_wait}, 2'b01);
    tick(1);
    chk("R4 load step not locked", st_locked, 0);
    tick(1);
    chk("R4 locked", {st_locked, ev_gain, irq}, 3'b111);
    @(posedge clk); #1;
    chk("R5 follows external", {sec_o, cyc_o}, {ext_sec, ext_cyc});

    pulse(sync_req);
    pulse(sync_cancel);
    tick(2);
    chk("R10 request and cancel ignored", {st_locked, st_wait}, 2'b10);
    tick(20);

    pulse(irq_clr);
    chk("R9 cleared", {ev_gain, ev_loss, irq}, 0);

    @(negedge clk);
    s0 = sec_o; c0 = cyc_o; ext_link_up = 0;
    @(negedge clk);
    chk("R6 left locked", {st_locked, ev_loss}, 2'b01);
    chk("R6 no jump", {sec_o, cyc_o},
        ((c0 == CPS - 1 ? (s0 + 1) % SMOD : s0) << CW) | (c0 == CPS - 1 ? 0 : c0 + 1));
    tick(7);

    pulse(sync_req);
    tick(15);
    chk("R8 request pending", {st_locked, st_wait}, 2'b01);
    pulse(sync_cancel);
    chk("R8 cancel", {st_locked, st_wait}, 0);

    pulse(irq_clr);
    pulse(sync_req);
    ext_link_up = 1;
    @(negedge clk) ext_link_up = 0;
    @(negedge clk);
    chk("R11 back to waiting", {st_locked, st_wait, ev_gain}, 3'b010);
    ext_link_up = 1; ext_time_ok = 0;
    tick(5);
    chk("R8 waits for time valid", {st_locked, st_wait}, 2'b01);
    ext_time_ok = 1;
    tick(3);
    chk("R4 locked again", st_locked, 1);
    tick(6);

    @(negedge clk) begin ext_link_up = 0; irq_clr = 1; end
    @(negedge clk) irq_clr = 0;
    chk("R9 set wins over clear", {ev_gain, ev_loss, irq}, 3'b011);

    tick(2700);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule